// File: doc/BRIEF.md
# ADC Multi-Mode Conversion Sequencer

This block is the control logic placed in front of an analog-to-digital converter core. It decides which of four analog input channels is converted next and sends each 8-bit result to one of four result registers. It also raises a sticky interrupt flag at the point the selected sequencing mode calls for. The converter core is reached through a plain handshake. The sequencer drives a one-cycle start pulse together with a channel number. The core later returns a one-cycle done pulse with the data word.

Five sequencing modes are provided:
- a single repeated channel whose results rotate through the registers;
- a one-pass scan of a channel mask;
- a looping scan of a channel mask;
- a two-channel ping-pong;
- a single-step scan that converts one channel for each start.

A sequence begins on one of two kinds of start. With immediate start, a start command begins it at once. With timer start, a timer-overflow pulse begins it. Either kind of start is ignored while a sequence is running. A stop command ends a running sequence once the conversion in flight has finished.

Configuration is captured when a sequence starts. Result register k is presented on `res_data[8k+7:8k]`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the following are all 0: `busy`, `conv_start`, `irq_flag`, `irq` and every result register.
- R2: Mode code 0 (fixed channel, continuous) converts `cfg_fix_ch` repeatedly. The n-th result since the start (counting from 0) goes to register n mod 4. `irq_flag` is set when the result that lands in register 3 is written.
- R3: Mode code 1 (scan, once) converts each channel whose `cfg_mask` bit is 1, once, from the lowest index to the highest. Each result goes to the register with the same index as its channel. `irq_flag` is set with the last result, and the block then goes idle.
- R4: Mode code 2 (scan, continuous) follows the R3 order and placement. It sets `irq_flag` at the end of every pass. It then restarts from the lowest selected channel without waiting for a new start.
- R5: Mode code 3 (dual channel, continuous) converts in the repeating order `cfg_pair_a`, `cfg_pair_b`, `cfg_pair_a`, `cfg_pair_b`. The results go to registers 0, 1, 2 and 3. `irq_flag` is set on each write to register 3.
- R6: Mode code 4 (single step) converts one channel for each start. The channel is the lowest selected channel numbered above the previous step's channel, and the choice wraps to the lowest selected channel. Its result goes to the register with the channel's index. `irq_flag` is set and the block goes idle.
- R7: With `cfg_trig_timer`=1 only a `tmr_ovf` pulse starts a sequence, and `cmd_start` does nothing. A `tmr_ovf` pulse that arrives while `busy` is 1 is ignored.
- R8: With `cfg_trig_timer`=0 only `cmd_start` starts a sequence, and `tmr_ovf` does nothing. With no start, `conv_start` stays 0 while the block is idle.
- R9: A start in mode 1, 2 or 4 with `cfg_mask`=0 leaves the block idle. A start with a mode code of 5, 6 or 7 also leaves it idle.
- R10: A `cmd_stop` pulse while `busy`=1 lets the conversion in flight finish and stores its result. The block then returns to idle with no further `conv_start`.
- R11: `irq_flag` stays set until a `cmd_irq_clr` pulse. If a set and a clear arrive in the same cycle, the set wins. `irq` equals `irq_flag` only while `cfg_irq_en`=1.
- R12: Each `conv_start` is high for one cycle. It rises in the cycle after the start is accepted, and again in the cycle after each `conv_done` that continues the sequence. Result registers change only at a clock edge where `conv_done` is high. `busy` is 1 from the first `conv_start` until the final result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Sequencing mode code (0..4 valid) |
| cfg_mask | input | 4 | Scan channel select, bit k = channel k |
| cfg_fix_ch | input | 2 | Channel for the fixed mode |
| cfg_pair_a | input | 2 | First channel of dual mode |
| cfg_pair_b | input | 2 | Second channel of dual mode |
| cfg_trig_timer | input | 1 | 1: timer-overflow start, 0: immediate start |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cmd_start | input | 1 | Immediate start pulse |
| cmd_stop | input | 1 | Stop request pulse |
| cmd_irq_clr | input | 1 | Interrupt flag clear pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| conv_start | output | 1 | Conversion start pulse to the converter core |
| conv_ch | output | 2 | Channel to convert |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 8 | Conversion result |
| res_data | output | 32 | Four result registers, register k at bits 8k+7:8k |
| busy | output | 1 | A sequence is running |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The checker relies on three assumptions about the inputs.
- The converter core returns `conv_done` only while a conversion is outstanding, with at least one cycle of latency.
- Start, stop and clear commands are single-cycle pulses.
- `cfg_mode` is not changed while `busy` is high.

The bench keeps to all three. It configures the block only while the block is idle. It pulses every command for one negative-edge-to-negative-edge cycle. Its model of the converter core answers each start after a fixed, chosen latency and stamps the channel into the low two bits of the data.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    MD_FIXED     = 3'd0,
    MD_SCAN_ONCE = 3'd1,
    MD_SCAN_LOOP = 3'd2,
    MD_DUAL      = 3'd3,
    MD_STEP      = 3'd4
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_pick.sv
// Finds the lowest set mask bit whose index is at or above a starting index.
module adc_seq_pick #(
  parameter int CH_N = 4,
  localparam int CW  = $clog2(CH_N)
) (
  input  logic [CH_N-1:0] mask,
  input  logic [CW:0]     from,
  output logic            found,
  output logic [CW-1:0]   ch
);

  always_comb begin
    found = 1'b0;
    ch    = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (mask[i] && (int'(from) <= i)) begin
        found = 1'b1;
        ch    = CW'(i);
      end
    end
  end

endmodule

// File: rtl/adc_seq_bank.sv
// Result register file with one indexed write port.
module adc_seq_bank #(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [N*DW-1:0] rd_flat
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic          hit;
    logic [DW-1:0] val_q;

    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wr_data;
      end
    end

    assign rd_flat[g*DW +: DW] = val_q;
  end

endmodule

// File: rtl/adc_seq_irq.sv
// Sticky interrupt flag; setting has priority over clearing.
module adc_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int DW   = 8,
  localparam int CW  = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode,
  input  logic [CH_N-1:0]  cfg_mask,
  input  logic [CW-1:0]    cfg_fix_ch,
  input  logic [CW-1:0]    cfg_pair_a,
  input  logic [CW-1:0]    cfg_pair_b,
  input  logic             cfg_trig_timer,
  input  logic             cfg_irq_en,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_irq_clr,
  input  logic             tmr_ovf,
  output logic             conv_start,
  output logic [CW-1:0]    conv_ch,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_data,
  output logic [CH_N*DW-1:0] res_data,
  output logic             busy,
  output logic             irq_flag,
  output logic             irq
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // State and captured configuration.
  seq_state_e      st_q, st_d;
  logic [2:0]      mode_q, mode_d;
  logic [CH_N-1:0] mask_q, mask_d;
  logic [CW-1:0]   fix_q, fix_d;
  logic [CW-1:0]   pa_q, pa_d;
  logic [CW-1:0]   pb_q, pb_d;
  logic [CW-1:0]   ch_q, ch_d;
  logic [CW-1:0]   slot_q, slot_d;
  logic            stop_q, stop_d;
  logic [CW:0]     step_q, step_d;

  logic            start_evt;
  logic            start_ok;
  logic [CW-1:0]   first_ch;
  logic            wr_en;
  logic [CW-1:0]   wr_idx;
  logic            irq_set;
  logic            more;
  logic [CW-1:0]   nslot;

  // Channel pickers.
  logic          nxt_found, base_found, step_found, loop_found;
  logic [CW-1:0] nxt_ch, base_ch, step_ch, loop_ch;
  logic [CW:0]   after_cur;

  assign after_cur = (CW+1)'(ch_q) + (CW+1)'(1);

  adc_seq_pick #(.CH_N(CH_N)) u_pick_next (
    .mask(mask_q), .from(after_cur), .found(nxt_found), .ch(nxt_ch));
  adc_seq_pick #(.CH_N(CH_N)) u_pick_loop (
    .mask(mask_q), .from('0), .found(loop_found), .ch(loop_ch));
  adc_seq_pick #(.CH_N(CH_N)) u_pick_base (
    .mask(cfg_mask), .from('0), .found(base_found), .ch(base_ch));
  adc_seq_pick #(.CH_N(CH_N)) u_pick_step (
    .mask(cfg_mask), .from(step_q), .found(step_found), .ch(step_ch));

  assign start_evt = cfg_trig_timer ? tmr_ovf : cmd_start;

  // Admission check and first channel at start.
  always_comb begin
    start_ok = 1'b0;
    first_ch = '0;
    case (cfg_mode)
      MD_FIXED: begin
        start_ok = 1'b1;
        first_ch = cfg_fix_ch;
      end
      MD_DUAL: begin
        start_ok = 1'b1;
        first_ch = cfg_pair_a;
      end
      MD_SCAN_ONCE, MD_SCAN_LOOP: begin
        start_ok = base_found;
        first_ch = base_ch;
      end
      MD_STEP: begin
        start_ok = base_found;
        first_ch = step_found ? step_ch : base_ch;
      end
      default: begin
        start_ok = 1'b0;
        first_ch = '0;
      end
    endcase
  end

  assign nslot = slot_q + CW'(1);

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    mask_d  = mask_q;
    fix_d   = fix_q;
    pa_d    = pa_q;
    pb_d    = pb_q;
    ch_d    = ch_q;
    slot_d  = slot_q;
    stop_d  = stop_q;
    step_d  = step_q;
    wr_en   = 1'b0;
    irq_set = 1'b0;
    more    = 1'b0;
    wr_idx  = ch_q;

    case (st_q)
      ST_IDLE: begin
        if (start_evt && start_ok) begin
          st_d   = ST_ISSUE;
          mode_d = cfg_mode;
          mask_d = cfg_mask;
          fix_d  = cfg_fix_ch;
          pa_d   = cfg_pair_a;
          pb_d   = cfg_pair_b;
          ch_d   = first_ch;
          slot_d = '0;
          stop_d = 1'b0;
        end
      end

      ST_ISSUE: begin
        st_d = ST_WAIT;
        if (cmd_stop) stop_d = 1'b1;
      end

      ST_WAIT: begin
        if (cmd_stop) stop_d = 1'b1;
        if (conv_done) begin
          wr_en = 1'b1;
          case (mode_q)
            MD_FIXED: begin
              wr_idx  = slot_q;
              irq_set = (slot_q == CW'(CH_N - 1));
              slot_d  = nslot;
              more    = 1'b1;
            end
            MD_DUAL: begin
              wr_idx  = slot_q;
              irq_set = (slot_q == CW'(CH_N - 1));
              slot_d  = nslot;
              ch_d    = nslot[0] ? pb_q : pa_q;
              more    = 1'b1;
            end
            MD_SCAN_ONCE: begin
              wr_idx = ch_q;
              if (nxt_found) begin
                ch_d = nxt_ch;
                more = 1'b1;
              end else begin
                irq_set = 1'b1;
              end
            end
            MD_SCAN_LOOP: begin
              wr_idx = ch_q;
              more   = 1'b1;
              if (nxt_found) begin
                ch_d = nxt_ch;
              end else begin
                irq_set = 1'b1;
                ch_d    = loop_found ? loop_ch : ch_q;
              end
            end
            default: begin
              wr_idx  = ch_q;
              irq_set = 1'b1;
              step_d  = after_cur;
            end
          endcase
          st_d = (more && !stop_d) ? ST_ISSUE : ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      mask_q <= '0;
      fix_q  <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
      ch_q   <= '0;
      slot_q <= '0;
      stop_q <= 1'b0;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      mask_q <= mask_d;
      fix_q  <= fix_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      ch_q   <= ch_d;
      slot_q <= slot_d;
      stop_q <= stop_d;
      step_q <= step_d;
    end
  end

  adc_seq_bank #(.N(CH_N), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (conv_data),
    .rd_flat (res_data)
  );

  adc_seq_irq u_irq (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (irq_set),
    .clr_i  (cmd_irq_clr),
    .en_i   (cfg_irq_en),
    .flag_o (irq_flag),
    .irq_o  (irq)
  );

  assign conv_start = (st_q == ST_ISSUE);
  assign conv_ch    = ch_q;
  assign busy       = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_N = 4,
  parameter int DW   = 8,
  localparam int CW  = $clog2(CH_N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_mode,
  input logic [CH_N-1:0]  cfg_mask,
  input logic             cfg_trig_timer,
  input logic             cmd_start,
  input logic             cmd_irq_clr,
  input logic             tmr_ovf,
  input logic             conv_start,
  input logic             conv_done,
  input logic [CH_N*DW-1:0] res_data,
  input logic             busy,
  input logic             irq_flag
);

  logic trig_seen;
  assign trig_seen = cfg_trig_timer ? tmr_ovf : cmd_start;

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_results_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(res_data));

  assert_no_idle_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig_seen) |=> !conv_start);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !cmd_irq_clr) |=> irq_flag);

  assert_empty_mask_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_mask == '0 &&
     (cfg_mode == 3'd1 || cfg_mode == 3'd2 || cfg_mode == 3'd4)) |=> !busy);

  assert_step_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && conv_done && cfg_mode == 3'd4) |=> !busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_N(CH_N), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_mode       (cfg_mode),
  .cfg_mask       (cfg_mask),
  .cfg_trig_timer (cfg_trig_timer),
  .cmd_start      (cmd_start),
  .cmd_irq_clr    (cmd_irq_clr),
  .tmr_ovf        (tmr_ovf),
  .conv_start     (conv_start),
  .conv_done      (conv_done),
  .res_data       (res_data),
  .busy           (busy),
  .irq_flag       (irq_flag)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_mode;
  logic [3:0]  cfg_mask;
  logic [1:0]  cfg_fix_ch, cfg_pair_a, cfg_pair_b;
  logic        cfg_trig_timer, cfg_irq_en;
  logic        cmd_start, cmd_stop, cmd_irq_clr, tmr_ovf;
  logic        conv_start;
  logic [1:0]  conv_ch;
  logic        conv_done;
  logic [7:0]  conv_data;
  logic [31:0] res_data;
  logic        busy, irq_flag, irq;

  always #2.5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
    .cfg_fix_ch(cfg_fix_ch), .cfg_pair_a(cfg_pair_a), .cfg_pair_b(cfg_pair_b),
    .cfg_trig_timer(cfg_trig_timer), .cfg_irq_en(cfg_irq_en),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_irq_clr(cmd_irq_clr),
    .tmr_ovf(tmr_ovf), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .res_data(res_data),
    .busy(busy), .irq_flag(irq_flag), .irq(irq));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Converter core model.
  int lat = 2;
  int cnt = 0;
  int seq = 0;
  int n_done = 0;
  int last_ch = 0;
  logic [1:0] pend_ch;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (conv_start === 1'b1) begin
      pend_ch = conv_ch;
      cnt = lat;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done = 1'b1;
        conv_data = {seq[5:0], pend_ch};
        seq++;
        n_done++;
        last_ch = int'(pend_ch);
      end
    end
  end

  // Behavioural reference: a queue of planned conversions.
  typedef struct { int ch; int dst; bit fire; } job_t;
  job_t jq[$];
  int   m_state, m_mode, m_mask, m_fix, m_pa, m_pb, m_step;
  bit   m_stop, m_flag;
  logic [7:0] m_res [4];

  function automatic void plan_pass();
    job_t j;
    int hi;
    int c;
    case (m_mode)
      0, 3: for (int k = 0; k < 4; k++) begin
        j.ch = (m_mode == 0) ? m_fix : ((k % 2) ? m_pb : m_pa);
        j.dst = k;
        j.fire = (k == 3);
        jq.push_back(j);
      end
      1, 2: begin
        hi = -1;
        for (int k = 0; k < 4; k++) if ((m_mask >> k) & 1) hi = k;
        for (int k = 0; k < 4; k++) if ((m_mask >> k) & 1) begin
          j.ch = k; j.dst = k; j.fire = (k == hi);
          jq.push_back(j);
        end
      end
      4: begin
        c = -1;
        for (int k = 3; k >= m_step; k--) if ((m_mask >> k) & 1) c = k;
        if (c < 0) for (int k = 3; k >= 0; k--) if ((m_mask >> k) & 1) c = k;
        if (c >= 0) begin
          j.ch = c; j.dst = c; j.fire = 1'b1;
          jq.push_back(j);
          m_step = c + 1;
        end
      end
      default: ;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_stop = 0; m_flag = 0; m_step = 0; m_mode = 0;
      m_mask = 0; m_fix = 0; m_pa = 0; m_pb = 0;
      for (int k = 0; k < 4; k++) m_res[k] = 8'h00;
      jq.delete();
    end else begin
      bit   setf;
      job_t j;
      setf = 1'b0;
      case (m_state)
        0: if (cfg_trig_timer ? tmr_ovf : cmd_start) begin
          m_mode = int'(cfg_mode); m_mask = int'(cfg_mask); m_fix = int'(cfg_fix_ch);
          m_pa = int'(cfg_pair_a); m_pb = int'(cfg_pair_b);
          jq.delete();
          plan_pass();
          if (jq.size() > 0) begin m_state = 1; m_stop = 0; end
        end
        1: begin m_state = 2; if (cmd_stop) m_stop = 1; end
        default: begin
          if (cmd_stop) m_stop = 1;
          if (conv_done) begin
            j = jq.pop_front();
            m_res[j.dst] = conv_data;
            setf = j.fire;
            if (jq.size() == 0 && (m_mode == 0 || m_mode == 2 || m_mode == 3)) plan_pass();
            if (jq.size() > 0 && !m_stop) m_state = 1;
            else begin m_state = 0; jq.delete(); end
          end
        end
      endcase
      if (setf) m_flag = 1;
      else if (cmd_irq_clr) m_flag = 0;
    end
  end

  function automatic string mtag();
    case (m_mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R12 busy", {31'd0, busy}, {31'd0, m_state != 0});
      chk("R12 conv_start", {31'd0, conv_start}, {31'd0, m_state == 1});
      if (m_state == 1) chk({mtag(), " conv_ch"}, {30'd0, conv_ch}, jq[0].ch);
      chk("R11 irq_flag", {31'd0, irq_flag}, {31'd0, m_flag});
      chk("R11 irq", {31'd0, irq}, {31'd0, m_flag && cfg_irq_en});
      chk({mtag(), " results"}, res_data, {m_res[3], m_res[2], m_res[1], m_res[0]});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic go_cmd();
    @(negedge clk) cmd_start = 1'b1; @(negedge clk) cmd_start = 1'b0;
  endtask
  task automatic go_tmr();
    @(negedge clk) tmr_ovf = 1'b1; @(negedge clk) tmr_ovf = 1'b0;
  endtask
  task automatic stop_now();
    @(negedge clk) cmd_stop = 1'b1; @(negedge clk) cmd_stop = 1'b0;
  endtask
  task automatic clr_irq();
    @(negedge clk) cmd_irq_clr = 1'b1; @(negedge clk) cmd_irq_clr = 1'b0;
  endtask
  task automatic wait_idle();
    tick();
    while (busy) tick();
  endtask
  task automatic wait_done(input int n);
    while (n_done < n) @(posedge clk);
    #1;
  endtask
  task automatic stop_in_flight(input string tag);
    int n0;
    @(negedge clk);
    while (conv_start !== 1'b1) @(negedge clk);
    n0 = n_done;
    stop_now();
    wait_idle();
    chk({tag, " one final result after stop"}, n_done, n0 + 1);
    repeat (6) tick();
    chk({tag, " stays idle after stop"}, {31'd0, busy}, 32'd0);
    chk({tag, " no further conversions"}, n_done, n0 + 1);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 1'b0;
    cfg_mode = 3'd0; cfg_mask = 4'h0; cfg_fix_ch = 2'd0; cfg_pair_a = 2'd0;
    cfg_pair_b = 2'd0; cfg_trig_timer = 1'b0; cfg_irq_en = 1'b1;
    cmd_start = 1'b0; cmd_stop = 1'b0; cmd_irq_clr = 1'b0; tmr_ovf = 1'b0;
    conv_done = 1'b0; conv_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 conv_start", {31'd0, conv_start}, 32'd0);
    chk("R1 irq_flag", {31'd0, irq_flag}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 results", res_data, 32'd0);

    // R2: fixed channel 2, rotation and every-fourth interrupt; R10 stop
    cfg_mode = 3'd0; cfg_fix_ch = 2'd2; lat = 3;
    n0 = n_done;
    go_cmd();
    wait_done(n0 + 3);
    chk("R2 no flag before fourth", {31'd0, irq_flag}, 32'd0);
    wait_done(n0 + 4);
    chk("R2 flag after fourth", {31'd0, irq_flag}, 32'd1);
    chk("R2 register 3 holds channel 2", {30'd0, res_data[25:24]}, 32'd2);
    wait_done(n0 + 5);
    stop_in_flight("R10");
    clr_irq();
    tick();
    chk("R11 flag cleared", {31'd0, irq_flag}, 32'd0);

    // R3: scan once over channels 1 and 3
    cfg_mode = 3'd1; cfg_mask = 4'b1010; lat = 2;
    n0 = n_done;
    go_cmd();
    wait_idle();
    chk("R3 two conversions", n_done, n0 + 2);
    chk("R3 register 1 channel", {30'd0, res_data[9:8]}, 32'd1);
    chk("R3 register 3 channel", {30'd0, res_data[25:24]}, 32'd3);
    chk("R3 flag at end of pass", {31'd0, irq_flag}, 32'd1);

    // R11: enable gating and stickiness
    cfg_irq_en = 1'b0;
    tick();
    chk("R11 irq gated off", {31'd0, irq}, 32'd0);
    chk("R11 flag still set", {31'd0, irq_flag}, 32'd1);
    cfg_irq_en = 1'b1;
    tick();
    chk("R11 irq follows flag", {31'd0, irq}, 32'd1);
    clr_irq();

    // R9: empty mask and unused mode codes
    cfg_mask = 4'b0000;
    n0 = n_done;
    go_cmd();
    repeat (4) tick();
    chk("R9 empty mask idle", {31'd0, busy}, 32'd0);
    cfg_mode = 3'd6; cfg_mask = 4'b1111;
    go_cmd();
    repeat (4) tick();
    chk("R9 unused mode idle", {31'd0, busy}, 32'd0);
    chk("R9 no conversions", n_done, n0);

    // R4: scan loop over channels 0, 2, 3 with single-cycle latency
    cfg_mode = 3'd2; cfg_mask = 4'b1101; lat = 1;
    n0 = n_done;
    go_cmd();
    wait_done(n0 + 3);
    chk("R4 flag after pass", {31'd0, irq_flag}, 32'd1);
    wait_done(n0 + 4);
    chk("R4 restart at lowest channel", last_ch, 0);
    chk("R4 still running", {31'd0, busy}, 32'd1);
    lat = 3;
    stop_in_flight("R10");
    clr_irq();

    // R5: dual channel 3 then 0
    cfg_mode = 3'd3; cfg_pair_a = 2'd3; cfg_pair_b = 2'd0; lat = 2;
    n0 = n_done;
    go_cmd();
    wait_done(n0 + 4);
    chk("R5 flag after group", {31'd0, irq_flag}, 32'd1);
    chk("R5 register 0 channel", {30'd0, res_data[1:0]}, 32'd3);
    chk("R5 register 1 channel", {30'd0, res_data[9:8]}, 32'd0);
    chk("R5 register 2 channel", {30'd0, res_data[17:16]}, 32'd3);
    chk("R5 register 3 channel", {30'd0, res_data[25:24]}, 32'd0);
    stop_in_flight("R10");
    clr_irq();

    // R6: single step over channels 1 and 2
    cfg_mode = 3'd4; cfg_mask = 4'b0110;
    n0 = n_done;
    go_cmd();
    wait_idle();
    chk("R6 first step channel", last_ch, 1);
    chk("R6 one conversion", n_done, n0 + 1);
    chk("R6 flag per step", {31'd0, irq_flag}, 32'd1);
    clr_irq();
    go_cmd();
    wait_idle();
    chk("R6 second step channel", last_ch, 2);
    go_cmd();
    wait_idle();
    chk("R6 wrap to lowest", last_ch, 1);
    chk("R6 register 2 channel", {30'd0, res_data[17:16]}, 32'd2);
    clr_irq();

    // R7: timer start, command ignored, overflow ignored while busy
    cfg_mode = 3'd1; cfg_mask = 4'b0001; cfg_trig_timer = 1'b1; lat = 6;
    n0 = n_done;
    go_cmd();
    repeat (3) tick();
    chk("R7 command ignored in timer mode", {31'd0, busy}, 32'd0);
    go_tmr();
    tick();
    chk("R7 overflow starts", {31'd0, busy}, 32'd1);
    go_tmr();
    go_tmr();
    wait_idle();
    repeat (4) tick();
    chk("R7 overflow while busy ignored", n_done, n0 + 1);
    chk("R7 idle after run", {31'd0, busy}, 32'd0);

    // R8: immediate start, overflow ignored
    cfg_trig_timer = 1'b0; lat = 2;
    go_tmr();
    repeat (3) tick();
    chk("R8 overflow ignored", {31'd0, busy}, 32'd0);
    go_cmd();
    tick();
    chk("R8 command starts", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R8 one conversion", n_done, n0 + 2);

    repeat (4) tick();
    cmp_on = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule